// File: doc/BRIEF.md
# Single to Double Precision Widener

This block takes a 32-bit single-precision floating-point bit pattern and produces the equivalent 64-bit double-precision pattern. Normal numbers, signed zeros, infinities and NaNs are widened by moving the fraction into the top of the wider fraction field and rebiasing the exponent. The same path forces the exponent to all ones for infinity and NaN, and to zero for a zero. A subnormal single has no implicit leading one. The block renormalizes it into a double-precision normal by shifting its fraction left one place per clock until the leading bit is set. The exponent drops by one for each shift.

A caller presents a word with `start` while `done` is high. `done` falls on the next edge and rises again when `result` holds the widened value. A start seen while `done` is low is dropped. A parameter replaces the iterative shifter with a one-cycle leading-zero count. The requirements below describe the default iterative variant.

Top module: `sp2dp_widen`

## Requirements
- R1: While reset is held low and right after it is released, `done` is 1 and `result` is all zeros.
- R2: For an input with exponent field (bits 30..23) from 1 to 254, the result is the input sign at bit 63, exponent field (bits 62..52) equal to the input exponent plus 896, and the 23 input fraction bits at bits 51..29 with zeros below.
- R3: For an input whose bits 30..0 are all zero, the result is the input sign at bit 63 and zeros everywhere else.
- R4: For an input with exponent field 255, the result has exponent field 0x7FF, the input sign at bit 63, and the input fraction at bits 51..29 with zeros below, so NaN payloads are kept.
- R5: For an input with exponent field 0 and nonzero fraction whose highest set fraction bit is at position p (0..22), the result has exponent field 874+p and fraction bits 51..0 equal to the fraction bits below position p, left-aligned, with zeros below.
- R6: `done` returns high on the (n+1)-th rising edge after the edge that accepted the start. n is 23-p for a subnormal input and 0 for every other input, so no conversion keeps `done` low for more than 24 cycles.
- R7: A `start` while `done` is low is ignored. The conversion in flight completes with its own value, and no further conversion follows.
- R8: A `start` seen with `done` high makes `done` go low on that same clock edge.
- R9: `result` changes only on the edge where `done` rises, and it holds its value while the block is idle.
- R10: The sign bit of every result equals the sign bit of the word that started it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion of `word_in`; taken only while `done` is high |
| word_in | input | 32 | Single-precision bit pattern, sampled with `start` |
| result | output | 64 | Double-precision bit pattern of the last finished conversion |
| done | output | 1 | High when idle and `result` is valid |

## Verification
The bench covers subnormal extremes. Fraction 1 needs 23 shifts and the worst-case exponent 874. Fraction 0x400000 needs a single shift. A design that miscounts the steps gives an exponent that is off by one, keeps the leading one in the fraction, or misses the stated latency. Signed zeros, infinities, NaN payloads and the largest and smallest normals are included, because a plain rebias would turn zero into a small normal or corrupt the all-ones exponent. A start is pulsed during every busy window. A block that accepts it would overwrite the in-flight result or produce an extra completion, and the scoreboard reports either.

// File: rtl/sp2dp_pkg.sv
`timescale 1ns/1ps
package sp2dp_pkg;
   typedef enum logic [1:0] {
      CLS_NORMAL  = 2'd0,
      CLS_ZERO    = 2'd1,
      CLS_SPECIAL = 2'd2,
      CLS_SUBNORM = 2'd3
   } fp_class_e;
endpackage

// File: rtl/sp2dp_classify.sv
`timescale 1ns/1ps
module sp2dp_classify
   import sp2dp_pkg::*;
#(
   parameter int SEXP  = 8,
   parameter int SFRAC = 23,
   parameter int DEXP  = 11,
   parameter int DFRAC = 52,
   localparam int SW   = 1 + SEXP + SFRAC,
   localparam int DW   = 1 + DEXP + DFRAC
) (
   input  logic [SW-1:0] word_i,
   output fp_class_e     cls_o,
   output logic [DW-1:0] copy_o
);
   localparam int SBIAS = (1 << (SEXP - 1)) - 1;
   localparam int DBIAS = (1 << (DEXP - 1)) - 1;
   localparam int GAP   = DBIAS - SBIAS;
   localparam int PAD   = DFRAC - SFRAC;

   logic              sgn;
   logic [SEXP-1:0]   sexp;
   logic [SFRAC-1:0]  sfrac;

   assign sgn   = word_i[SW-1];
   assign sexp  = word_i[SW-2 -: SEXP];
   assign sfrac = word_i[SFRAC-1:0];

   always_comb begin
      if (sexp == '1)
         cls_o = CLS_SPECIAL;
      else if (sexp != '0)
         cls_o = CLS_NORMAL;
      else if (sfrac == '0)
         cls_o = CLS_ZERO;
      else
         cls_o = CLS_SUBNORM;
   end

   always_comb begin
      unique case (cls_o)
         CLS_NORMAL:  copy_o = {sgn, DEXP'(sexp) + DEXP'(GAP), sfrac, {PAD{1'b0}}};
         CLS_SPECIAL: copy_o = {sgn, {DEXP{1'b1}}, sfrac, {PAD{1'b0}}};
         CLS_ZERO:    copy_o = {sgn, {(DW-1){1'b0}}};
         default:     copy_o = '0;
      endcase
   end
endmodule

// File: rtl/sp2dp_normalizer.sv
`timescale 1ns/1ps
module sp2dp_normalizer #(
   parameter int SFRAC     = 23,
   parameter int EW        = 12,
   parameter int START_EXP = -126,
   parameter bit USE_LZC   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_i,
   input  logic                 en_i,
   input  logic [SFRAC-1:0]     frac_i,
   output logic                 lead_o,
   output logic [SFRAC-1:0]     frac_o,
   output logic signed [EW-1:0] exp_o
);
   localparam int MW = SFRAC + 1;

   logic [MW-1:0]        mant_q;
   logic signed [EW-1:0] exp_q;

   assign lead_o = mant_q[MW-1];
   assign frac_o = mant_q[MW-2:0];
   assign exp_o  = exp_q;

   generate
      if (USE_LZC) begin : g_lzc
         function automatic int lead_zeros(input logic [MW-1:0] v);
            int n;
            n = MW;
            for (int i = 0; i < MW; i++)
               if (v[i]) n = MW - 1 - i;
            return n;
         endfunction

         logic [MW-1:0] seed;
         int            lz;
         assign seed = {1'b0, frac_i};
         assign lz   = lead_zeros(seed);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mant_q <= '0;
               exp_q  <= '0;
            end else if (load_i) begin
               mant_q <= seed << lz;
               exp_q  <= EW'(START_EXP) - EW'(lz);
            end
         end
      end else begin : g_iter
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mant_q <= '0;
               exp_q  <= '0;
            end else if (load_i) begin
               mant_q <= {1'b0, frac_i};
               exp_q  <= EW'(START_EXP);
            end else if (en_i && !mant_q[MW-1]) begin
               mant_q <= {mant_q[MW-2:0], 1'b0};
               exp_q  <= exp_q - EW'(1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sp2dp_widen.sv
`timescale 1ns/1ps
module sp2dp_widen
   import sp2dp_pkg::*;
#(
   parameter int SEXP    = 8,
   parameter int SFRAC   = 23,
   parameter int DEXP    = 11,
   parameter int DFRAC   = 52,
   parameter bit USE_LZC = 1'b0,
   localparam int SW     = 1 + SEXP + SFRAC,
   localparam int DW     = 1 + DEXP + DFRAC
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [SW-1:0] word_in,
   output logic [DW-1:0] result,
   output logic          done
);
   localparam int SBIAS = (1 << (SEXP - 1)) - 1;
   localparam int DBIAS = (1 << (DEXP - 1)) - 1;
   localparam int EW    = DEXP + 1;
   localparam int PAD   = DFRAC - SFRAC;

   generate
      if (DEXP <= SEXP || DFRAC < SFRAC) begin : g_bad_width
         $error("target format must be wider than source format");
      end
      if (DBIAS - SBIAS <= SFRAC) begin : g_bad_range
         $error("target exponent range cannot hold renormalized subnormals");
      end
   endgenerate

   logic                 busy_q;
   logic [SW-1:0]        word_q;
   logic [DW-1:0]        result_q;
   fp_class_e            cls;
   logic [DW-1:0]        copy_val;
   logic                 accept;
   logic                 norm_en;
   logic                 lead;
   logic [SFRAC-1:0]     norm_frac;
   logic signed [EW-1:0] norm_exp;
   logic signed [EW-1:0] biased;

   assign accept  = start && !busy_q;
   assign norm_en = busy_q && (cls == CLS_SUBNORM) && !lead;
   assign biased  = norm_exp + EW'(DBIAS);

   sp2dp_classify #(
      .SEXP(SEXP), .SFRAC(SFRAC), .DEXP(DEXP), .DFRAC(DFRAC)
   ) u_cls (
      .word_i (word_q),
      .cls_o  (cls),
      .copy_o (copy_val)
   );

   sp2dp_normalizer #(
      .SFRAC(SFRAC), .EW(EW), .START_EXP(1 - SBIAS), .USE_LZC(USE_LZC)
   ) u_norm (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .en_i   (norm_en),
      .frac_i (word_in[SFRAC-1:0]),
      .lead_o (lead),
      .frac_o (norm_frac),
      .exp_o  (norm_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         word_q   <= '0;
         result_q <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            word_q <= word_in;
         end
      end else if (cls != CLS_SUBNORM) begin
         result_q <= copy_val;
         busy_q   <= 1'b0;
      end else if (lead) begin
         result_q <= {word_q[SW-1], biased[DEXP-1:0], norm_frac, {PAD{1'b0}}};
         busy_q   <= 1'b0;
      end
   end

   assign result = result_q;
   assign done   = !busy_q;
endmodule

// File: rtl/sp2dp_checker.sv
`timescale 1ns/1ps
module sp2dp_checker #(
   parameter int SW    = 32,
   parameter int DW    = 64,
   parameter int DEXP  = 11,
   parameter int DFRAC = 52,
   parameter int LIMIT = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [SW-1:0] word_in,
   input logic [DW-1:0] result,
   input logic          done
);
   logic sign_q;
   int   low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sign_q  <= 1'b0;
         low_cnt <= 0;
      end else begin
         if (start && done) sign_q <= word_in[SW-1];
         low_cnt <= done ? 0 : low_cnt + 1;
      end
   end

   assert_fall_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start && done |=> !done);

   assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> $rose(done));

   assert_sign_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> result[DW-1] == sign_q);

   assert_no_subnormal_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (result[DW-2 -: DEXP] != '0) || (result[DFRAC-1:0] == '0));

   assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      low_cnt <= LIMIT);
endmodule

bind sp2dp_widen sp2dp_checker #(
   .SW(SW), .DW(DW), .DEXP(DEXP), .DFRAC(DFRAC), .LIMIT(SFRAC + 1)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in),
   .result(result), .done(done)
);

// File: tb/sim_sp2dp_widen.sv
`timescale 1ns/1ps
module sim_sp2dp_widen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] word_in = '0;
   logic [63:0] result;
   logic        done;

   int total = 0;
   int bad   = 0;

   typedef struct {
      logic [63:0] val;
      int          lat;
      string       req;
   } item_t;
   item_t sb[$];
   logic [63:0] last_val = '0;

   always #10 clk = ~clk;

   sp2dp_widen u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in),
      .result(result), .done(done)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_dp(input logic [31:0] w, output int lat, output string req);
      logic [7:0]  e;
      logic [22:0] f;
      logic [63:0] t;
      int          p;
      e = w[30:23];
      f = w[22:0];
      lat = 1;
      if (e == 8'hFF) begin
         req = "R4";
         return {w[31], 11'h7FF, f, 29'b0};
      end
      if (e != 0) begin
         req = "R2";
         return {w[31], 11'(e) + 11'd896, f, 29'b0};
      end
      if (f == 0) begin
         req = "R3";
         return {w[31], 63'b0};
      end
      req = "R5";
      p = 0;
      for (int i = 0; i < 23; i++) if (f[i]) p = i;
      lat = 23 - p + 1;
      t = 64'(f) << (52 - p);
      return {w[31], 11'(874 + p), t[51:0]};
   endfunction

   // monitor: scoreboard pop on each rise of done
   initial begin
      int  low = 0;
      bit  prev = 1'b1;
      item_t it;
      wait (rst_n);
      forever begin
         @(negedge clk);
         if (!done) low++;
         else begin
            if (!prev) begin
               if (sb.size() == 0)
                  check(1'b0, "R7 unexpected completion", result, last_val);
               else begin
                  it = sb.pop_front();
                  check(result == it.val, it.req, result, it.val);
                  check(low == it.lat, "R6 latency", 64'(low), 64'(it.lat));
                  last_val = it.val;
               end
            end
            low = 0;
         end
         prev = done;
      end
   end

   task automatic send(input logic [31:0] w, input bit poke);
      item_t it;
      @(negedge clk);
      start   = 1'b1;
      word_in = w;
      it.val  = ref_dp(w, it.lat, it.req);
      sb.push_back(it);
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b0, "R8 done low after start", 64'(done), 64'd0);
      if (poke && !done) begin
         // R7: this start must be dropped
         word_in = ~w;
         start   = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
   endtask

   initial begin
      #(20 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] x;
      repeat (3) @(negedge clk);
      check(done == 1'b1 && result == '0, "R1 reset in progress", result, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b1, "R1 done after reset", 64'(done), 64'd1);
      check(result == '0, "R1 result after reset", result, 64'd0);

      send(32'h3F80_0000, 1'b0);   // R2 one
      check(result == 64'h3FF0_0000_0000_0000, "R2 one", result, 64'h3FF0_0000_0000_0000);
      send(32'hC049_0FDB, 1'b1);   // R2 with R7 poke
      send(32'h0080_0000, 1'b0);   // R2 smallest normal
      send(32'h7F7F_FFFF, 1'b1);   // R2 largest normal
      send(32'h0000_0000, 1'b0);   // R3
      send(32'h8000_0000, 1'b1);   // R3 negative zero
      send(32'h7F80_0000, 1'b0);   // R4 infinity
      send(32'hFF80_0000, 1'b1);   // R4 negative infinity
      send(32'h7FC0_0001, 1'b0);   // R4 NaN payload
      send(32'h0000_0001, 1'b1);   // R5 deepest subnormal
      check(result == 64'h36A0_0000_0000_0000, "R5 deepest", result, 64'h36A0_0000_0000_0000);
      send(32'h0040_0000, 1'b0);   // R5 one shift
      send(32'h807F_FFFF, 1'b1);   // R5 R10 negative
      send(32'h0001_2345, 1'b0);   // R5

      x = 32'h1234_5678;
      for (int k = 0; k < 40; k++) begin
         x = x ^ (x << 13);
         x = x ^ (x >> 17);
         x = x ^ (x << 5);
         send((k % 2 == 0) ? (x & 32'h807F_FFFF) : x, k[0]);
      end

      // R7 and R9: idle after poked conversions, nothing more completes
      repeat (4) @(negedge clk);
      check(done == 1'b1, "R7 stays idle", 64'(done), 64'd1);
      check(result == last_val, "R9 result held", result, last_val);
      check(sb.size() == 0, "R7 scoreboard drained", 64'(sb.size()), 64'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule